// File: doc/BRIEF.md
# MESI Coherence State Controller

This block holds the four-state coherence status for a small, directly indexed set of lines in a snooping cache that sits on a shared bus. Each cycle it can take one request from the local processor (read or write, naming a line index) and one observed bus event from another cache (a read, or an announcement that the other cache intends to write), naming a possibly different line. From the stored status it decides, in the same cycle, whether the local access can finish without using the bus. If it cannot, it decides which bus request to raise. It also raises a "line is held here" response and a writeback request for dirty data that another cache needs.

A line filled by a read while no other cache reports holding it becomes exclusive-clean. A later local write to it then needs no bus transaction. Data storage, tag comparison, replacement and arbitration belong to surrounding logic. The bus response to a read miss (`shared_in`) is expected in the same cycle as the request.

When a local request and an observed bus event name the same line in the same cycle, the bus event is applied first. The local request is then judged against the status left by that event.

Top module: `mesi_line_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, every line is set to Invalid, and `cpu_state` then reads 2'b00 for every index.
- R2: `cpu_state` shows the stored status of line `cpu_idx` as it was before the current edge, encoded Invalid = 2'b00, Shared = 2'b01, Exclusive = 2'b10, Modified = 2'b11.
- R3: A local read of an Invalid line raises `bus_rd_req` in the same cycle with `cpu_hit` low. The line becomes Exclusive if `shared_in` is 0 and Shared if it is 1.
- R4: A local read of a Shared, Exclusive or Modified line raises `cpu_hit` with neither bus request, and leaves the status unchanged.
- R5: A local write to an Invalid line raises `bus_inv_req` with `cpu_hit` low, and the line becomes Modified.
- R6: A local write to a Shared line raises `bus_inv_req` with `cpu_hit` low, and the line becomes Modified.
- R7: A local write to an Exclusive or Modified line raises `cpu_hit` with no bus request, and the line becomes Modified.
- R8: An observed read (`snp_own` = 0) of a Modified line raises `wb_req` and `shared_out`, and the line becomes Shared.
- R9: An observed read of an Exclusive or Shared line raises `shared_out` without `wb_req`, and the line becomes Shared. An observed read of an Invalid line raises neither signal and the line stays Invalid.
- R10: An observed write intent (`snp_own` = 1) moves a Modified, Exclusive or Shared line to Invalid, raises `wb_req` only if the line was Modified, and never raises `shared_out`.
- R11: When the local request and the observed event name the same line in one cycle, the event is applied first. The local request's outputs and final status follow from the status the event leaves.
- R12: A line named by neither the local request nor the observed event keeps its status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Local request present this cycle |
| cpu_write | input | 1 | Local request is a write (1) or a read (0) |
| cpu_idx | input | IDX_W | Line named by the local request and by `cpu_state` |
| shared_in | input | 1 | Another cache reports holding the line on a read miss |
| snp_valid | input | 1 | Observed bus event present this cycle |
| snp_own | input | 1 | Observed event is a write intent (1) or a read (0) |
| snp_idx | input | IDX_W | Line named by the observed event |
| bus_rd_req | output | 1 | Issue a read-miss request on the bus |
| bus_inv_req | output | 1 | Issue a request announcing intent to write |
| cpu_hit | output | 1 | Local access completes without a bus transaction |
| shared_out | output | 1 | Response: this cache holds the observed line |
| wb_req | output | 1 | Write back dirty data for the observed line |
| cpu_state | output | 2 | Stored status of line `cpu_idx` |

## Verification
The local path and the observed-event path can act in the same cycle, on different lines or on the same line. The bench drives every combination of starting status, local operation, `shared_in` value and event kind, both with the two indices equal and with them apart. When they are equal, expected outputs come from applying the event to the line first and the local request second. Every line's status is then read back through `cpu_state`, which also shows that the line not named by the event was left alone.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_E = 2'b10,
        ST_M = 2'b11
    } line_state_t;

    typedef struct packed {
        line_state_t next;
        logic        wb;
        logic        shr;
    } snoop_res_t;

    typedef struct packed {
        line_state_t next;
        logic        rd_req;
        logic        inv_req;
        logic        hit;
    } local_res_t;

    // Effect of a foreign bus event on a line in state st.
    function automatic snoop_res_t snoop_step(line_state_t st, logic own);
        snoop_res_t r;
        r.next = st;
        r.wb   = 1'b0;
        r.shr  = 1'b0;
        if (own) begin
            r.next = ST_I;
            r.wb   = (st == ST_M);
        end else if (st != ST_I) begin
            r.next = ST_S;
            r.shr  = 1'b1;
            r.wb   = (st == ST_M);
        end
        return r;
    endfunction

    // Effect of a local access on a line in state st.
    function automatic local_res_t local_step(line_state_t st, logic wr, logic shared_seen);
        local_res_t r;
        r.next    = st;
        r.rd_req  = 1'b0;
        r.inv_req = 1'b0;
        r.hit     = 1'b0;
        if (wr) begin
            r.next = ST_M;
            if (st == ST_E || st == ST_M) r.hit     = 1'b1;
            else                          r.inv_req = 1'b1;
        end else if (st == ST_I) begin
            r.rd_req = 1'b1;
            r.next   = shared_seen ? ST_S : ST_E;
        end else begin
            r.hit = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     loc_we,
    input  logic [IDX_W-1:0]         loc_idx,
    input  line_state_t              loc_next,
    input  logic                     snp_we,
    input  logic [IDX_W-1:0]         snp_idx,
    input  line_state_t              snp_next,
    output line_state_t [LINES-1:0]  lines_q
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst)
                lines_q[g] <= ST_I;
            else if (loc_we && loc_idx == IDX_W'(g))
                lines_q[g] <= loc_next;
            else if (snp_we && snp_idx == IDX_W'(g))
                lines_q[g] <= snp_next;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> ($countones(lines_q) == 0)); // R1

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
(
    input  logic        valid,
    input  logic        own,
    input  line_state_t cur,
    output snoop_res_t  res
);

    always_comb begin
        if (valid) begin
            res = snoop_step(cur, own);
        end else begin
            res.next = cur;
            res.wb   = 1'b0;
            res.shr  = 1'b0;
        end
    end

endmodule

// File: rtl/mesi_local_unit.sv
module mesi_local_unit
    import mesi_pkg::*;
(
    input  logic        valid,
    input  logic        wr,
    input  logic        shared_seen,
    input  line_state_t cur,
    output local_res_t  res
);

    always_comb begin
        if (valid) begin
            res = local_step(cur, wr, shared_seen);
        end else begin
            res.next    = cur;
            res.rd_req  = 1'b0;
            res.inv_req = 1'b0;
            res.hit     = 1'b0;
        end
    end

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_valid,
    input  logic             cpu_write,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic             shared_in,
    input  logic             snp_valid,
    input  logic             snp_own,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             bus_rd_req,
    output logic             bus_inv_req,
    output logic             cpu_hit,
    output logic             shared_out,
    output logic             wb_req,
    output logic [1:0]       cpu_state
);

    line_state_t [LINES-1:0] lines_q;
    line_state_t             cur_cpu;
    line_state_t             cur_snp;
    line_state_t             loc_base;
    snoop_res_t              snp_res;
    local_res_t              loc_res;
    logic                    same_line;

    assign cur_cpu   = lines_q[cpu_idx];
    assign cur_snp   = lines_q[snp_idx];
    assign same_line = snp_valid && (snp_idx == cpu_idx);
    // Bus event on the same line is resolved before the local access.
    assign loc_base  = same_line ? snp_res.next : cur_cpu;

    mesi_snoop_unit u_snoop (
        .valid (snp_valid),
        .own   (snp_own),
        .cur   (cur_snp),
        .res   (snp_res)
    );

    mesi_local_unit u_local (
        .valid       (cpu_valid),
        .wr          (cpu_write),
        .shared_seen (shared_in),
        .cur         (loc_base),
        .res         (loc_res)
    );

    mesi_line_store #(.LINES(LINES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .loc_we   (cpu_valid),
        .loc_idx  (cpu_idx),
        .loc_next (loc_res.next),
        .snp_we   (snp_valid),
        .snp_idx  (snp_idx),
        .snp_next (snp_res.next),
        .lines_q  (lines_q)
    );

    assign bus_rd_req  = loc_res.rd_req;
    assign bus_inv_req = loc_res.inv_req;
    assign cpu_hit     = loc_res.hit;
    assign shared_out  = snp_res.shr;
    assign wb_req      = snp_res.wb;
    assign cpu_state   = cur_cpu;

    AST_ONE_BUS_REQ: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd_req && bus_inv_req) && !(cpu_hit && (bus_rd_req || bus_inv_req))); // R4
    AST_READ_FILL: assert property (@(posedge clk) disable iff (rst)
        bus_rd_req |=> lines_q[$past(cpu_idx)] == ($past(shared_in) ? ST_S : ST_E)); // R3
    AST_WRITE_LANDS_M: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_write) |=> lines_q[$past(cpu_idx)] == ST_M); // R7
    AST_WB_DIRTY: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> lines_q[snp_idx] == ST_M); // R8
    AST_OWN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_own && !(cpu_valid && cpu_idx == snp_idx))
        |=> lines_q[$past(snp_idx)] == ST_I); // R10

endmodule

// File: tb/mesi_line_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_line_ctrl_tb_top;

    localparam int LINES = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cpu_valid = 1'b0, cpu_write = 1'b0, shared_in = 1'b0;
    logic             snp_valid = 1'b0, snp_own = 1'b0;
    logic [IDX_W-1:0] cpu_idx = '0, snp_idx = '0;
    logic             bus_rd_req, bus_inv_req, cpu_hit, shared_out, wb_req;
    logic [1:0]       cpu_state;

    int errors = 0;
    int checks = 0;
    int exp_st [LINES];
    bit done = 0;

    always #5 clk = ~clk;

    mesi_line_ctrl #(.LINES(LINES)) dut_i (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_idx(cpu_idx),
        .shared_in(shared_in),
        .snp_valid(snp_valid), .snp_own(snp_own), .snp_idx(snp_idx),
        .bus_rd_req(bus_rd_req), .bus_inv_req(bus_inv_req), .cpu_hit(cpu_hit),
        .shared_out(shared_out), .wb_req(wb_req), .cpu_state(cpu_state)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Read every line's status back through cpu_state (no requests active).
    task automatic check_all(string tag_a, int ia, string tag_b, int ib);
        cpu_valid = 0; snp_valid = 0;
        for (int k = 0; k < LINES; k++) begin
            cpu_idx = IDX_W'(k);
            #1;
            if (k == ia)      check(tag_a, $sformatf("state line %0d", k), cpu_state, exp_st[k]);
            else if (k == ib) check(tag_b, $sformatf("state line %0d", k), cpu_state, exp_st[k]);
            else              check("R12", $sformatf("state line %0d", k), cpu_state, exp_st[k]);
        end
    endtask

    // One cycle of stimulus; outputs judged against the requirement model.
    task automatic step(bit cv, bit cw, int ci, bit sh, bit sv, bit so, int si);
        int ns, base, nl;
        bit e_wb, e_shr, e_rd, e_inv, e_hit;
        string tl, ts;
        @(negedge clk);
        cpu_valid = cv; cpu_write = cw; cpu_idx = IDX_W'(ci); shared_in = sh;
        snp_valid = sv; snp_own = so; snp_idx = IDX_W'(si);
        e_wb = 0; e_shr = 0; ns = exp_st[si];
        ts = "R9";
        if (sv) begin
            if (so) begin
                ts = "R10"; e_wb = (exp_st[si] == 3); ns = 0;
            end else begin
                ts = (exp_st[si] == 3) ? "R8" : "R9";
                e_shr = (exp_st[si] != 0); e_wb = (exp_st[si] == 3);
                ns = (exp_st[si] == 0) ? 0 : 1;
            end
        end
        base = (sv && si == ci) ? ns : exp_st[ci];
        e_rd = 0; e_inv = 0; e_hit = 0; nl = base;
        if (!cw) tl = (base == 0) ? "R3" : "R4";
        else     tl = (base == 0) ? "R5" : (base == 1) ? "R6" : "R7";
        if (sv && cv && si == ci) tl = "R11";
        if (cv) begin
            if (!cw) begin
                if (base == 0) begin e_rd = 1; nl = sh ? 1 : 2; end
                else e_hit = 1;
            end else begin
                nl = 3;
                if (base >= 2) e_hit = 1; else e_inv = 1;
            end
        end
        #4;
        check(tl, "bus_rd_req", bus_rd_req, e_rd);
        check(tl, "bus_inv_req", bus_inv_req, e_inv);
        check(tl, "cpu_hit", cpu_hit, e_hit);
        check(ts, "shared_out", shared_out, e_shr);
        check(ts, "wb_req", wb_req, e_wb);
        @(posedge clk);
        if (sv) exp_st[si] = ns;
        if (cv) exp_st[ci] = nl;
        #1;
        check_all(tl, cv ? ci : -1, ts, sv ? si : -1);
    endtask

    task automatic set_state(int idx, int s);
        step(0, 0, idx, 0, 1, 1, idx);
        if (s == 3) step(1, 1, idx, 0, 0, 0, idx);
        if (s == 2) step(1, 0, idx, 0, 0, 0, idx);
        if (s == 1) step(1, 0, idx, 1, 0, 0, idx);
    endtask

    initial begin
        for (int k = 0; k < LINES; k++) exp_st[k] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        check_all("R1", -1, "R1", -1);
        for (int k = 0; k < LINES; k++) check("R1", "post reset line", exp_st[k], 0);

        // Encoding of each status through cpu_state.
        for (int s = 0; s < 4; s++) begin
            set_state(2, s);
            @(negedge clk); cpu_idx = 3'd2; #1;
            check("R2", "encoding", cpu_state, s);
        end

        // Exhaustive sweep over status, operation, response and event kind.
        begin
            int combo = 0;
            for (int s = 0; s < 4; s++)
              for (int lop = 0; lop < 3; lop++)
                for (int sh = 0; sh < 2; sh++)
                  for (int sop = 0; sop < 3; sop++)
                    for (int same = 0; same < 2; same++) begin
                        int a, b;
                        a = combo % LINES;
                        b = (a + 3) % LINES;
                        combo++;
                        set_state(a, s);
                        set_state(b, (s + 1) % 4);
                        step(lop != 0, lop == 2, a, sh[0], sop != 0, sop == 2, same ? a : b);
                    end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_800_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule